// File: doc/BRIEF.md
# Enable-Gated Fixed-Latency Execution Pipeline

This block is an execution unit placed between an input register and one output register per result port. An issue-enable flip-flop sits in front of it. When the issue strobe is high, the operands and a small flag word are captured and a one is loaded into the enable bit. That bit then moves down a chain of stage bits, one step per clock, in step with the data it belongs to. A stage whose enable bit is low keeps its contents, so idle parts of the pipe do not toggle.

There are two result ports. The sum port returns the 32-bit wrapped sum of the operands, together with the captured flags, two clocks after issue. The product port returns the low 32 bits of the product four clocks after issue. No valid strobe comes out. A consumer knows each port's latency and reads the port on that exact cycle. A free-running variant, chosen by a parameter, ignores the enable chain. In that variant every stage, including the input register, updates on every clock, so a result is only present for one cycle.

Top module: `exec_wave_pipe`

## Requirements
- R1: On a clock edge where `issue` is 1 (and `rst` is 0), the operands and `flags_in` are loaded into the input register and the front enable bit becomes 1. The captured flags appear on `sum_flags` together with that operation's sum.
- R2: On a clock edge where `issue` is 0, the front enable bit becomes 0 and the input register keeps its value. Operand pins driven without issue never reach a result port.
- R3: For an issue at clock edge k, `sum_out` takes the value (x + y) mod 2^32 at edge k+2. This holds for carry-out cases such as 0xFFFFFFFF + 1 = 0.
- R4: For an issue at clock edge k, `prod_out` takes the low 32 bits of x*y at edge k+4. For example, 0xFFFFFFFF * 0xFFFFFFFF gives 0x00000001.
- R5: With ALWAYS_ON = 0, an output register keeps its last result until the next result for that port arrives.
- R6: Issues on consecutive clock edges are all accepted. Each result appears at its own issue edge plus the port latency, one result per cycle.
- R7: A synchronous active-high `rst` clears the enable chain, the input register, every stage and both output registers to zero at the next clock edge.
- R8: With ALWAYS_ON = 1, every stage and the input register load on every edge whatever `issue` is. After edge t, `sum_out` equals the sum of the operand pins sampled at edge t-2, and `prod_out` equals the low product of those sampled at edge t-4. A result therefore stays valid for one clock.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| issue | input | 1 | Issue strobe for the current operand set |
| opnd_x | input | W (32) | First operand |
| opnd_y | input | W (32) | Second operand |
| flags_in | input | FW (4) | Flag word issued with the operands |
| sum_out | output | W (32) | Sum port output register |
| sum_flags | output | FW (4) | Flags travelling with the sum result |
| prod_out | output | W (32) | Product port output register, low half |

## Verification
A sum result is due two rising edges after the edge that takes its issue, and a product result is due four edges after. The bench numbers each rising edge from the end of reset and logs the issue bit and operand pins seen at that edge. After every edge it takes the log entry exactly two or four edges back to decide whether a new result is due and what it must be. If no result is due, it expects the previous value to stay. A second instance built free-running receives the same pins, and its outputs are compared every cycle against the pins from exactly two or four edges earlier.

// File: rtl/exec_wave_pipe.sv
module exec_wave_pipe #(
  parameter int W = 32,
  parameter int FW = 4,
  parameter int LAT_A = 2,
  parameter int LAT_B = 4,
  parameter bit ALWAYS_ON = 1'b0
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          issue,
  input  logic [W-1:0]  opnd_x,
  input  logic [W-1:0]  opnd_y,
  input  logic [FW-1:0] flags_in,
  output logic [W-1:0]  sum_out,
  output logic [FW-1:0] sum_flags,
  output logic [W-1:0]  prod_out
);
  localparam int LMAX = (LAT_A > LAT_B) ? LAT_A : LAT_B;
  localparam int AW = W + FW;

  logic [LMAX-1:0] en_q;
  logic [W-1:0]    in_x, in_y;
  logic [FW-1:0]   in_f;
  logic            load;
  logic [AW-1:0]   a_src;
  logic [W-1:0]    b_src;
  logic [LAT_A:1][AW-1:0] a_st;
  logic [LAT_B:1][W-1:0]  b_st;

  assign load  = issue | ALWAYS_ON;
  assign a_src = {in_f, in_x + in_y};
  assign b_src = in_x * in_y;

  always_ff @(posedge clk) begin
    if (rst) begin
      in_x <= '0;
      in_y <= '0;
      in_f <= '0;
      en_q <= '0;
    end else begin
      if (load) begin
        in_x <= opnd_x;
        in_y <= opnd_y;
        in_f <= flags_in;
      end
      en_q[0] <= issue;
      for (int i = 1; i < LMAX; i++) en_q[i] <= en_q[i-1];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      a_st <= '0;
    end else begin
      if (ALWAYS_ON || en_q[0]) a_st[1] <= a_src;
      for (int i = 2; i <= LAT_A; i++)
        if (ALWAYS_ON || en_q[i-1]) a_st[i] <= a_st[i-1];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      b_st <= '0;
    end else begin
      if (ALWAYS_ON || en_q[0]) b_st[1] <= b_src;
      for (int i = 2; i <= LAT_B; i++)
        if (ALWAYS_ON || en_q[i-1]) b_st[i] <= b_st[i-1];
    end
  end

  assign sum_out   = a_st[LAT_A][W-1:0];
  assign sum_flags = a_st[LAT_A][AW-1:W];
  assign prod_out  = b_st[LAT_B];
endmodule

module exec_wave_pipe_chk #(
  parameter int W = 32,
  parameter int LAT_A = 2,
  parameter int LAT_B = 4,
  parameter int LMAX = 4,
  parameter bit ALWAYS_ON = 1'b0
) (
  input logic            clk,
  input logic            rst,
  input logic            issue,
  input logic [LMAX-1:0] en_q,
  input logic [W-1:0]    in_x,
  input logic [W-1:0]    in_y,
  input logic [W-1:0]    sum_out,
  input logic [W-1:0]    prod_out
);
  // R1
  issue_sets_en_chk: assert property (@(posedge clk) disable iff (rst)
    issue |=> en_q[0]);

  // R2
  idle_clears_en_chk: assert property (@(posedge clk) disable iff (rst)
    !issue |=> !en_q[0]);

  // R2
  idle_holds_input_chk: assert property (@(posedge clk) disable iff (rst)
    (!ALWAYS_ON && !issue) |=> ($stable(in_x) && $stable(in_y)));

  // R5
  sum_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!ALWAYS_ON && !en_q[LAT_A-1]) |=> $stable(sum_out));

  // R5
  prod_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!ALWAYS_ON && !en_q[LAT_B-1]) |=> $stable(prod_out));

  for (genvar i = 1; i < LMAX; i++) begin : g_wave
    // R6
    wave_advance_chk: assert property (@(posedge clk) disable iff (rst)
      en_q[i-1] |=> en_q[i]);
  end

  // R7
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> (sum_out == '0 && prod_out == '0 && en_q == '0));
endmodule

bind exec_wave_pipe exec_wave_pipe_chk #(
  .W(W), .LAT_A(LAT_A), .LAT_B(LAT_B), .LMAX(LMAX), .ALWAYS_ON(ALWAYS_ON)
) u_chk (
  .clk(clk), .rst(rst), .issue(issue), .en_q(en_q),
  .in_x(in_x), .in_y(in_y), .sum_out(sum_out), .prod_out(prod_out)
);

// File: tb/test_exec_wave_pipe.sv
module test_exec_wave_pipe;
  localparam int LA = 2;
  localparam int LB = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic issue = 1'b0;
  logic [31:0] ox = '0, oy = '0;
  logic [3:0]  fl = '0;
  logic [31:0] sum_out, prod_out, f_sum, f_prod;
  logic [3:0]  sum_flags, f_flags;

  always #5 clk = ~clk;

  exec_wave_pipe #(.ALWAYS_ON(1'b0)) i_exec_wave_pipe (
    .clk(clk), .rst(rst), .issue(issue), .opnd_x(ox), .opnd_y(oy), .flags_in(fl),
    .sum_out(sum_out), .sum_flags(sum_flags), .prod_out(prod_out));

  exec_wave_pipe #(.ALWAYS_ON(1'b1)) i_exec_wave_pipe_free (
    .clk(clk), .rst(rst), .issue(issue), .opnd_x(ox), .opnd_y(oy), .flags_in(fl),
    .sum_out(f_sum), .sum_flags(f_flags), .prod_out(f_prod));

  int checks = 0, fails = 0, cyc = 0;
  bit done = 1'b0;
  bit        hi [1024];
  bit [31:0] hx [1024];
  bit [31:0] hy [1024];
  bit [3:0]  hf [1024];
  bit [31:0] exA = '0, exB = '0;
  bit [3:0]  exF = '0;

  function automatic bit [31:0] f_add(bit [31:0] a, bit [31:0] b);
    return a + b;
  endfunction

  function automatic bit [31:0] f_mul(bit [31:0] a, bit [31:0] b);
    bit [63:0] p = 64'(a) * 64'(b);
    return p[31:0];
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic step(bit iss, bit [31:0] x, bit [31:0] y, bit [3:0] f, string tagb);
    bit newA, newB;
    issue = iss; ox = x; oy = y; fl = f;
    @(posedge clk);
    cyc++;
    hi[cyc] = iss; hx[cyc] = x; hy[cyc] = y; hf[cyc] = f;
    @(negedge clk);
    newA = (cyc > LA) && hi[cyc-LA];
    newB = (cyc > LB) && hi[cyc-LB];
    if (newA) begin
      exA = f_add(hx[cyc-LA], hy[cyc-LA]);
      exF = hf[cyc-LA];
    end
    if (newB) exB = f_mul(hx[cyc-LB], hy[cyc-LB]);
    chk(newA ? {"R3 ", tagb} : "R5 R2 sum", sum_out, exA);
    chk(newA ? {"R1 flags ", tagb} : "R5 flags", 32'(sum_flags), 32'(exF));
    chk(newB ? {"R4 ", tagb} : "R5 R2 prod", prod_out, exB);
    if (cyc > LA) chk("R8 sum", f_sum, f_add(hx[cyc-LA], hy[cyc-LA]));
    if (cyc > LB) chk("R8 prod", f_prod, f_mul(hx[cyc-LB], hy[cyc-LB]));
  endtask

  task automatic do_reset();
    rst = 1'b1; issue = 1'b0;
    @(posedge clk);
    @(negedge clk);
    chk("R7 sum", sum_out, '0);
    chk("R7 flags", 32'(sum_flags), '0);
    chk("R7 prod", prod_out, '0);
    chk("R7 free sum", f_sum, '0);
    chk("R7 free prod", f_prod, '0);
    rst = 1'b0;
    cyc = 0; exA = '0; exB = '0; exF = '0;
  endtask

  task automatic rand_steps(int n);
    for (int i = 0; i < n; i++)
      step(($urandom % 10) < 6, $urandom, $urandom, 4'($urandom), "rand");
  endtask

  initial begin
    void'($urandom(32'd7351));
    @(posedge clk);
    @(negedge clk);
    do_reset();
    step(1'b1, 32'hFFFF_FFFF, 32'h1, 4'hA, "wrap");
    step(1'b1, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 4'h5, "max");
    step(1'b0, 32'h1234_5678, 32'h0BAD_F00D, 4'hF, "idle");
    step(1'b0, 32'h0001_0000, 32'h0001_0000, 4'h3, "idle");
    for (int i = 0; i < 10; i++)
      step(1'b1, $urandom, $urandom, 4'(i), "R6 burst");
    for (int i = 0; i < 6; i++)
      step(1'b0, $urandom, $urandom, 4'($urandom), "drain");
    step(1'b1, 32'h0001_0000, 32'h0001_0000, 4'h7, "R4 low-half zero");
    rand_steps(500);
    do_reset();
    rand_steps(200);
    for (int i = 0; i < 6; i++) step(1'b0, $urandom, $urandom, 4'h0, "drain");
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule